// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Unit

This block performs 32-bit integer multiplication and division over many cycles and keeps the outcome in a pair of result registers, HI and LO. A caller presents two operands, selects one of four operations with a 2-bit code and pulses a start strobe. The unit then works on its own for a fixed number of cycles, one product bit or one quotient bit per cycle, while `busy` is held high.

A multiply leaves the full double-width product split across the pair, with the upper half in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. Signed operations take the magnitudes of the operands, run the same unsigned iteration and then correct the signs of the results. No overflow flag exists. A caller that needs a single-word product reads LO and checks HI itself. The two result registers are visible on separate read ports, so either one can be moved out independently.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `busy` is 0 and both `hi_out` and `lo_out` are 0.
- R2: A `start` sampled while idle makes `busy` high for exactly 32 cycles. HI and LO both take their new values at the clock edge where `busy` falls, and they do not change while `busy` is high.
- R3: A `start` sampled while `busy` is high is ignored: the running operation completes with its own operands and its own timing.
- R4: Op code 2'b01 (unsigned multiply) gives {HI,LO} = the 64-bit unsigned product of `src_a` and `src_b`.
- R5: Op code 2'b00 (signed multiply) gives {HI,LO} = the 64-bit two's-complement product of `src_a` and `src_b`.
- R6: Op code 2'b11 (unsigned divide) with a nonzero divisor `src_b` gives LO = quotient and HI = remainder, where `src_a` = LO*`src_b` + HI and HI < `src_b`.
- R7: Op code 2'b10 (signed divide) with a nonzero divisor truncates the quotient toward zero and gives the remainder the sign of the dividend. For 0x80000000 divided by 0xFFFFFFFF the result is LO = 0x80000000 and HI = 0.
- R8: A divide of either kind by zero completes normally with LO = 0xFFFFFFFF and HI = the dividend `src_a`.
- R9: Between operations HI and LO hold their values. No overflow is signalled; the low word of a product always appears on LO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; only accepted while idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation iterates |
| hi_out | output | 32 | HI register: upper product half or remainder |
| lo_out | output | 32 | LO register: lower product half or quotient |

## Verification
The assertions check on every cycle that an accepted start raises `busy` and that each run lasts exactly 32 cycles. They also check that the result registers stay frozen while busy and while idle. On completion they check the unsigned product, the unsigned division identity and the divide-by-zero values against operands captured at acceptance. The signed sign-correction rules, including the most-negative-over-minus-one case and mixed-sign remainders, are shown only by the bench's directed scenarios. The same holds for a start that arrives in the middle of a run and leaves that run undisturbed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
    parameter int W = 32
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         is_div,
    output logic         neg_main,
    output logic         neg_rem
);
    import muldiv_pkg::*;

    logic sgn;

    always_comb begin
        sgn      = (op == OP_MUL_S) || (op == OP_DIV_S);
        is_div   = op[1];
        mag_a    = (sgn && opa[W-1]) ? (~opa + 1'b1) : opa;
        mag_b    = (sgn && opb[W-1]) ? (~opb + 1'b1) : opb;
        neg_main = sgn && (opa[W-1] ^ opb[W-1]);
        neg_rem  = sgn && op[1] && opa[W-1];
    end
endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
    parameter int W = 32
) (
    input  logic         is_div,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0]   sum;
    logic [W:0]   shl;
    logic [W+1:0] diff;

    always_comb begin
        sum  = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opnd} : '0);
        shl  = {acc_hi, acc_lo[W-1]};
        diff = {1'b0, shl} - {2'b00, opnd};
        if (!is_div) begin
            nxt_hi = sum[W:1];
            nxt_lo = {sum[0], acc_lo[W-1:1]};
        end else if (!diff[W+1]) begin
            nxt_hi = diff[W-1:0];
            nxt_lo = {acc_lo[W-2:0], 1'b1};
        end else begin
            nxt_hi = shl[W-1:0];
            nxt_lo = {acc_lo[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
    parameter int W = 32
) (
    input  logic         is_div,
    input  logic         neg_main,
    input  logic         neg_rem,
    input  logic         div0,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] raw_hi,
    input  logic [W-1:0] raw_lo,
    output logic [W-1:0] fin_hi,
    output logic [W-1:0] fin_lo
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = {raw_hi, raw_lo};
        if (neg_main) prod = ~prod + 1'b1;
        if (!is_div) begin
            fin_hi = prod[2*W-1:W];
            fin_lo = prod[W-1:0];
        end else if (div0) begin
            fin_hi = dvd;
            fin_lo = '1;
        end else begin
            fin_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
            fin_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_main;
        logic          neg_rem;
        logic          div0;
        logic [W-1:0]  dvd;
        logic [W-1:0]  opnd;
        logic [W-1:0]  acc_hi;
        logic [W-1:0]  acc_lo;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } md_state_t;

    md_state_t st_d, st_q;

    logic [W-1:0] mag_a, mag_b;
    logic         p_div, p_neg_main, p_neg_rem;
    logic [W-1:0] stp_hi, stp_lo;
    logic [W-1:0] fix_hi, fix_lo;

    mdu_operand_prep #(.W(W)) u_prep (
        .op       (op),
        .opa      (src_a),
        .opb      (src_b),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .is_div   (p_div),
        .neg_main (p_neg_main),
        .neg_rem  (p_neg_rem)
    );

    mdu_step #(.W(W)) u_step (
        .is_div (st_q.is_div),
        .acc_hi (st_q.acc_hi),
        .acc_lo (st_q.acc_lo),
        .opnd   (st_q.opnd),
        .nxt_hi (stp_hi),
        .nxt_lo (stp_lo)
    );

    mdu_result_fix #(.W(W)) u_fix (
        .is_div   (st_q.is_div),
        .neg_main (st_q.neg_main),
        .neg_rem  (st_q.neg_rem),
        .div0     (st_q.div0),
        .dvd      (st_q.dvd),
        .raw_hi   (stp_hi),
        .raw_lo   (stp_lo),
        .fin_hi   (fix_hi),
        .fin_lo   (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.cnt      = '0;
                st_d.is_div   = p_div;
                st_d.neg_main = p_neg_main;
                st_d.neg_rem  = p_neg_rem;
                st_d.div0     = p_div && (src_b == '0);
                st_d.dvd      = src_a;
                st_d.acc_hi   = '0;
                st_d.acc_lo   = p_div ? mag_a : mag_b;
                st_d.opnd     = p_div ? mag_b : mag_a;
            end
        end else begin
            st_d.acc_hi = stp_hi;
            st_d.acc_lo = stp_lo;
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.hi   = fix_hi;
                st_d.lo   = fix_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign hi_out = st_q.hi;
    assign lo_out = st_q.lo;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic         busy,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out
);
    logic [W-1:0]   cap_a, cap_b;
    logic [1:0]     cap_op;
    logic [15:0]    run_len;
    logic [2*W-1:0] prod_u, div_id;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            cap_op  <= '0;
            run_len <= '0;
        end else if (start && !busy) begin
            cap_a   <= src_a;
            cap_b   <= src_b;
            cap_op  <= op;
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    always_comb begin
        prod_u = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
        div_id = {{W{1'b0}}, lo_out} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, hi_out};
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2 R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 16'(W)));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy ? ($stable(hi_out) && $stable(lo_out)) : 1'b1));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi_out) && $stable(lo_out)));

    // R4
    mulu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op == 2'b01) |-> ({hi_out, lo_out} == prod_u));

    // R6
    divu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op == 2'b11 && cap_b != '0) |->
        (div_id == {{W{1'b0}}, cap_a} && hi_out < cap_b));

    // R8
    divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op[1] && cap_b == '0) |->
        (lo_out == '1 && hi_out == cap_a));
endmodule

bind muldiv_unit mdu_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .src_a  (src_a),
    .src_b  (src_b),
    .busy   (busy),
    .hi_out (hi_out),
    .lo_out (lo_out)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    localparam int  W        = 32;
    localparam time CLK_PER  = 10ns;
    localparam int  RUN_CYC  = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         busy;
    logic [W-1:0] hi_out, lo_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    muldiv_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .busy(busy), .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one op, count busy cycles; optionally pulse a second start mid-run.
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input bit disturb, output int ncyc);
        @(negedge clk);
        op = o; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ncyc = 0;
        while (busy && ncyc < 100) begin
            ncyc++;
            if (disturb && ncyc == 5) begin
                op = 2'b01; src_a = 32'h1234_5678; src_b = 32'h0000_0003; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (ncyc >= 100) begin
            errors++;
            $display("FAIL R2 watchdog: busy stuck, actual=%0d expected=%0d", ncyc, RUN_CYC);
        end
    endtask

    task automatic t_mul(input string req, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        int n;
        logic [63:0] exp;
        longint sa, sb;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        exp = sgn ? 64'(sa * sb) : ({32'h0, a} * {32'h0, b});
        run_op(sgn ? 2'b00 : 2'b01, a, b, 1'b0, n);
        check64("R2 run length", 64'(n), 64'(RUN_CYC));
        check64(req, {hi_out, lo_out}, exp);
    endtask

    task automatic t_div(input string req, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        int n;
        logic [31:0] eq, er;
        longint sa, sb;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        if (b == 0) begin
            eq = 32'hFFFF_FFFF; er = a;
        end else if (sgn) begin
            eq = 32'(sa / sb); er = 32'(sa % sb);
        end else begin
            eq = a / b; er = a % b;
        end
        run_op(sgn ? 2'b10 : 2'b11, a, b, 1'b0, n);
        check64("R2 run length", 64'(n), 64'(RUN_CYC));
        check64(req, {hi_out, lo_out}, {er, eq});
    endtask

    task automatic t_reset;
        check64("R1 reset state", {31'h0, busy, hi_out, lo_out}, 64'h0);
    endtask

    task automatic t_ignore_start;
        int n;
        run_op(2'b11, 32'd1000, 32'd7, 1'b1, n);
        check64("R3 run length with mid-run start", 64'(n), 64'(RUN_CYC));
        check64("R3 result unaffected by mid-run start", {hi_out, lo_out}, {32'd6, 32'd142});
        repeat (3) @(negedge clk);
        check64("R3 no second run", {63'h0, busy}, 64'h0);
    endtask

    task automatic t_hold;
        logic [63:0] snap;
        t_mul("R9 low word on LO, no overflow flag", 1'b0, 32'hFFFF_FFFF, 32'h0000_0010);
        snap = {hi_out, lo_out};
        op = 2'b10; src_a = 32'h5555_5555; src_b = 32'h3;
        repeat (10) @(negedge clk);
        check64("R9 results hold while idle", {hi_out, lo_out}, snap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul("R4 unsigned multiply small", 1'b0, 32'd12345, 32'd6789);
        t_mul("R4 unsigned multiply max", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_mul("R5 signed multiply neg*pos", 1'b1, 32'hFFFF_FFF9, 32'd1000);
        t_mul("R5 signed multiply neg*neg", 1'b1, 32'h8000_0000, 32'h8000_0000);
        t_mul("R5 signed multiply pos*neg", 1'b1, 32'h0001_0003, 32'hFFFE_0001);
        t_div("R6 unsigned divide", 1'b0, 32'd1000000, 32'd37);
        t_div("R6 unsigned divide large", 1'b0, 32'hFFFF_FFFF, 32'h0000_0010);
        t_div("R6 unsigned divide smaller dividend", 1'b0, 32'd5, 32'd9);
        t_div("R7 signed divide neg/pos", 1'b1, 32'hFFFF_FFF9, 32'd2);
        t_div("R7 signed divide pos/neg", 1'b1, 32'd7, 32'hFFFF_FFFE);
        t_div("R7 signed divide neg/neg", 1'b1, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
        t_div("R7 signed divide min/-1", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        t_div("R8 unsigned divide by zero", 1'b0, 32'hDEAD_BEEF, 32'h0);
        t_div("R8 signed divide by zero", 1'b1, 32'h8765_4321, 32'h0);
        t_ignore_start();
        t_hold();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule